// File: doc/BRIEF.md
# Indirect Dword Register Window

This block is a small, eight-byte register window. Through it, a host reaches a much larger internal register array owned by a parent block. The host sees only two window dwords. The low dword holds an 8-bit index register in its third byte. The high dword is a 32-bit data register. The index picks one internal dword, whose byte address is the index times four.

Reading the data register returns a shadow copy of the picked internal dword. Writing the data register sends all four of its bytes into the array. The parent supplies, for every byte, a plain overwrite mask and a write-one-to-clear mask, and the block merges the new data under those masks. One cycle after any window write, the shadow copy reloads from the array, so it always follows what the array now holds.

The parent owns the array storage, its masks and any side effects. The block only reports a one-cycle command pulse when a forwarded write lands on the two command bytes of the array. Array bytes at or above the array size are never written and read back as zero.

Top module: `dword_window`

## Requirements
- R1: After reset the index register and data register are zero, so every byte of both window dwords reads zero. Neither arr_we nor cmd_pulse is asserted.
- R2: Low window dword layout: byte 2 (bits 23:16) is the index register, fully writable through win_be[2] and read back there. Bytes 0, 1 and 3 always read zero and ignore writes. The index changes only on a write to byte 2.
- R3: A window write to the high dword (win_dw=1) with any byte enable set replaces only the enabled bytes of the data register. The bytes that are not enabled keep their old value before the dword is forwarded.
- R4: In the same cycle as such a data write, arr_we is high and arr_addr equals index×4. arr_be marks every in-range byte of the dword, whatever win_be was. A window write with win_be all zero causes no array write.
- R5: Each forwarded array byte becomes ((old & ~wmask) | (new & wmask)) & ~(new & w1c). The parent guarantees that wmask and w1c share no set bit.
- R6: One cycle after any window write, including a write that only changes the index, the data register reloads from the array dword at index×4, as that dword stands after the write.
- R7: When index×4 is at or above ARR_BYTES, a data write changes no array byte, and the reload gives zero.
- R8: When the picked dword crosses the array end, only bytes below ARR_BYTES are written, and the bytes above it reload as zero.
- R9: cmd_pulse is high for the one cycle after a forwarded write whose in-range bytes include array byte CMD_OFF or CMD_OFF+1. It is low after every other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_we | input | 1 | Window write strobe |
| win_dw | input | 1 | Window dword: 0 = index dword, 1 = data dword |
| win_be | input | 4 | Byte enables for the window write |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data for the dword picked by win_dw |
| arr_addr | output | 10 | Byte address of the picked array dword (index×4) |
| arr_rdata | input | 32 | Array dword at arr_addr, from the parent |
| arr_wmask | input | 32 | Overwrite mask for the dword at arr_addr |
| arr_w1c | input | 32 | Write-one-to-clear mask for the dword at arr_addr |
| arr_we | output | 1 | Array write strobe |
| arr_be | output | 4 | Array byte enables |
| arr_wdata | output | 32 | Merged array write data |
| cmd_pulse | output | 1 | One-cycle command strobe |

## Verification
The assertions check, on every cycle, several rules about the array port. A write to the array happens only while a data-dword write is in progress, and it never happens at an address beyond the array. Bits covered by neither mask leave the array unchanged, and the two masks never overlap. The index holds still when byte 2 is not written, and each command pulse follows an array write.

Some behaviour can only be shown by the bench's scenarios, because it needs a model of the array contents. This covers the exact cleared-versus-overwritten value of each byte and the value the shadow reloads one cycle later. It also covers truncation at a dword that crosses the end of the array, and which index values produce the command pulse.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
    localparam int SEL_W  = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
        logic              reload;
        logic              cmd;
    } dwin_state_t;
endpackage

// File: rtl/dwin_span.sv
module dwin_span
    import dwin_pkg::*;
#(
    parameter  int ARR_BYTES = 160,
    parameter  int CMD_OFF   = 20,
    localparam int AW        = SEL_W + 2
) (
    input  logic [SEL_W-1:0] sel,
    output logic [AW-1:0]    base,
    output logic [LANES-1:0] lane_ok,
    output logic [LANES-1:0] lane_cmd
);
    assign base = {sel, 2'b00};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW-1:0] byte_a;
        assign byte_a      = base + AW'(i);
        assign lane_ok[i]  = int'(byte_a) < ARR_BYTES;
        assign lane_cmd[i] = (int'(byte_a) == CMD_OFF) || (int'(byte_a) == CMD_OFF + 1);
    end
endmodule

// File: rtl/dwin_merge.sv
module dwin_merge
    import dwin_pkg::*;
(
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    input  logic [DATA_W-1:0] wmask,
    input  logic [DATA_W-1:0] w1c,
    output logic [DATA_W-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_byte
        logic [7:0] kept;
        assign kept = (old_val[i*8 +: 8] & ~wmask[i*8 +: 8]) | (new_val[i*8 +: 8] & wmask[i*8 +: 8]);
        assign merged[i*8 +: 8] = kept & ~(new_val[i*8 +: 8] & w1c[i*8 +: 8]);
    end
endmodule

// File: rtl/dword_window.sv
module dword_window
    import dwin_pkg::*;
#(
    parameter  int ARR_BYTES = 160,
    parameter  int CMD_OFF   = 20,
    localparam int AW        = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic              win_dw,
    input  logic [LANES-1:0]  win_be,
    input  logic [DATA_W-1:0] win_wdata,
    output logic [DATA_W-1:0] win_rdata,
    output logic [AW-1:0]     arr_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] arr_wmask,
    input  logic [DATA_W-1:0] arr_w1c,
    output logic              arr_we,
    output logic [LANES-1:0]  arr_be,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              cmd_pulse
);
    dwin_state_t st_q, st_d;

    logic [LANES-1:0]  lane_ok, lane_cmd;
    logic [DATA_W-1:0] data_new, reload_val;
    logic              any_wr, hdr_wr, dat_wr;

    dwin_span #(.ARR_BYTES(ARR_BYTES), .CMD_OFF(CMD_OFF)) u_span (
        .sel      (st_q.sel),
        .base     (arr_addr),
        .lane_ok  (lane_ok),
        .lane_cmd (lane_cmd)
    );

    dwin_merge u_merge (
        .old_val (arr_rdata),
        .new_val (data_new),
        .wmask   (arr_wmask),
        .w1c     (arr_w1c),
        .merged  (arr_wdata)
    );

    always_comb begin
        any_wr = win_we && (win_be != '0);
        hdr_wr = any_wr && !win_dw;
        dat_wr = any_wr && win_dw;

        for (int i = 0; i < LANES; i++) begin
            data_new[i*8 +: 8]   = win_be[i] ? win_wdata[i*8 +: 8] : st_q.data[i*8 +: 8];
            reload_val[i*8 +: 8] = lane_ok[i] ? arr_rdata[i*8 +: 8] : 8'h00;
        end

        st_d        = st_q;
        st_d.reload = any_wr;
        st_d.cmd    = dat_wr && ((lane_ok & lane_cmd) != '0);

        if (hdr_wr && win_be[2]) begin
            st_d.sel = win_wdata[23:16];
        end

        if (dat_wr) begin
            st_d.data = data_new;
        end else if (st_q.reload) begin
            st_d.data = reload_val;
        end

        arr_we    = dat_wr && (lane_ok != '0);
        arr_be    = dat_wr ? lane_ok : '0;
        win_rdata = win_dw ? st_q.data : {8'h00, st_q.sel, 16'h0000};
        cmd_pulse = st_q.cmd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dwin_chk.sv
module dwin_chk
    import dwin_pkg::*;
#(
    parameter  int ARR_BYTES = 160,
    localparam int AW        = SEL_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_we,
    input logic              win_dw,
    input logic [LANES-1:0]  win_be,
    input logic [DATA_W-1:0] win_wdata,
    input logic [AW-1:0]     arr_addr,
    input logic [DATA_W-1:0] arr_rdata,
    input logic [DATA_W-1:0] arr_wmask,
    input logic [DATA_W-1:0] arr_w1c,
    input logic              arr_we,
    input logic [DATA_W-1:0] arr_wdata,
    input logic              cmd_pulse
);
    AST_FWD_ON_DATA_WR: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (win_we && win_dw && (win_be != '0)));  // R4

    AST_NO_WR_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arr_addr) >= ARR_BYTES) |-> !arr_we);  // R7

    AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ((arr_wdata & ~arr_wmask & ~arr_w1c) == (arr_rdata & ~arr_wmask & ~arr_w1c)));  // R5

    AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ((arr_wmask & arr_w1c) == '0));  // R5

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_we && !win_dw && win_be[2]) |=> $stable(arr_addr));  // R2

    AST_CMD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse |-> $past(arr_we));  // R9

    logic unused_ok;
    assign unused_ok = ^win_wdata;
endmodule

bind dword_window dwin_chk #(.ARR_BYTES(ARR_BYTES)) u_dwin_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_we    (win_we),
    .win_dw    (win_dw),
    .win_be    (win_be),
    .win_wdata (win_wdata),
    .arr_addr  (arr_addr),
    .arr_rdata (arr_rdata),
    .arr_wmask (arr_wmask),
    .arr_w1c   (arr_w1c),
    .arr_we    (arr_we),
    .arr_wdata (arr_wdata),
    .cmd_pulse (cmd_pulse)
);

// File: tb/dword_window_bench.sv
`timescale 1ns/1ps
module dword_window_bench;
    localparam int ARR = 158;
    localparam int CMD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_we = 1'b0;
    logic        win_dw = 1'b0;
    logic [3:0]  win_be = '0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic [9:0]  arr_addr;
    logic [31:0] arr_rdata, arr_wmask, arr_w1c, arr_wdata;
    logic        arr_we, cmd_pulse;
    logic [3:0]  arr_be;

    logic [7:0] mem   [0:1023];
    logic [7:0] model [0:1023];
    int checks = 0;
    int fails = 0;
    logic [31:0] shadow;

    always #4 clk = ~clk;

    dword_window #(.ARR_BYTES(ARR), .CMD_OFF(CMD)) u_dword_window (
        .clk, .rst_n, .win_we, .win_dw, .win_be, .win_wdata, .win_rdata,
        .arr_addr, .arr_rdata, .arr_wmask, .arr_w1c, .arr_we, .arr_be,
        .arr_wdata, .cmd_pulse
    );

    function automatic logic [7:0] wm_of(int a);
        return 8'(a * 13) ^ 8'h3C;
    endfunction
    function automatic logic [7:0] w1c_of(int a);
        return ~wm_of(a) & 8'h5A;
    endfunction

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            arr_rdata[i*8 +: 8] = (int'(arr_addr) + i < ARR) ? mem[int'(arr_addr) + i] : 8'h00;
            arr_wmask[i*8 +: 8] = wm_of(int'(arr_addr) + i);
            arr_w1c[i*8 +: 8]   = w1c_of(int'(arr_addr) + i);
        end
    end

    always @(posedge clk) begin
        if (arr_we) begin
            for (int i = 0; i < 4; i++) begin
                if (arr_be[i]) mem[int'(arr_addr) + i] <= arr_wdata[i*8 +: 8];
            end
        end
    end

    // vector: {sel[44:37], be[36:33], wdata[32:1], exp_cmd[0]}
    localparam logic [44:0] VEC [8] = '{
        {8'd3,   4'hF, 32'hA5A5_5A5A, 1'b0},
        {8'd5,   4'h1, 32'h0000_00FF, 1'b1},
        {8'd5,   4'h8, 32'hFF00_0000, 1'b1},
        {8'd0,   4'h6, 32'h00FF_FF00, 1'b0},
        {8'd39,  4'hF, 32'h1234_5678, 1'b0},
        {8'd40,  4'hF, 32'hDEAD_BEEF, 1'b0},
        {8'd200, 4'h3, 32'h0000_FFFF, 1'b0},
        {8'd12,  4'hF, 32'hFFFF_FFFF, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reload(input logic [7:0] sel);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            v[i*8 +: 8] = (int'(sel) * 4 + i < ARR) ? model[int'(sel) * 4 + i] : 8'h00;
        end
        return v;
    endfunction

    task automatic host_write(input logic dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        win_we = 1'b1; win_dw = dw; win_be = be; win_wdata = d;
        #1;
    endtask

    task automatic host_release();
        @(negedge clk);
        win_we = 1'b0; win_be = '0;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 1024; a++) begin
            mem[a]   = 8'(a * 7 + 3);
            model[a] = 8'(a * 7 + 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        win_dw = 1'b0; #1;
        check(win_rdata == 32'h0, "R1 idx dword", win_rdata, 32'h0);
        win_dw = 1'b1; #1;
        check(win_rdata == 32'h0, "R1 data dword", win_rdata, 32'h0);
        check(!arr_we && !cmd_pulse, "R1 strobes idle", {arr_we, cmd_pulse}, 0);
        shadow = 32'h0;

        for (int k = 0; k < 8; k++) begin
            logic [7:0]  sel;
            logic [3:0]  be, exp_be;
            logic [31:0] wd, nd, rl;
            bit          ec;
            sel = VEC[k][44:37]; be = VEC[k][36:33]; wd = VEC[k][32:1]; ec = VEC[k][0];
            // index write, then reload (R2, R6, R7, R8)
            host_write(1'b0, 4'b0100, {8'h00, sel, 16'h0});
            host_release();
            win_dw = 1'b0; #1;
            check(win_rdata == {8'h00, sel, 16'h0}, "R2 index readback", win_rdata, {8'h00, sel, 16'h0});
            @(negedge clk); win_dw = 1'b1; #1;
            rl = exp_reload(sel);
            check(win_rdata == rl, "R6 reload after index write", win_rdata, rl);
            shadow = rl;
            // data write (R3, R4, R5, R7, R8, R9)
            for (int i = 0; i < 4; i++) nd[i*8 +: 8] = be[i] ? wd[i*8 +: 8] : shadow[i*8 +: 8];
            for (int i = 0; i < 4; i++) exp_be[i] = (int'(sel) * 4 + i < ARR);
            host_write(1'b1, be, wd);
            check(arr_we == (exp_be != 0), "R4 R7 arr_we", {31'h0, arr_we}, {31'h0, exp_be != 0});
            check((arr_be == (exp_be & {4{exp_be != 0}})) && (!arr_we || arr_addr == 10'(sel) * 4),
                  "R4 R8 addr and lanes", {18'h0, arr_be, arr_addr}, {18'h0, exp_be, 10'(sel) * 10'd4});
            for (int i = 0; i < 4; i++) begin
                int a;
                a = int'(sel) * 4 + i;
                if (a < ARR) model[a] = ((model[a] & ~wm_of(a)) | (nd[i*8 +: 8] & wm_of(a))) & ~(nd[i*8 +: 8] & w1c_of(a));
            end
            host_release();
            check(cmd_pulse == ec, "R9 command strobe", {31'h0, cmd_pulse}, {31'h0, ec});
            @(negedge clk); #1;
            check(cmd_pulse == 1'b0, "R9 strobe one cycle", {31'h0, cmd_pulse}, 32'h0);
            rl = exp_reload(sel);
            check(win_rdata == rl, "R6 R8 reload after data write", win_rdata, rl);
            for (int i = 0; i < 4; i++) begin
                int a;
                a = int'(sel) * 4 + i;
                if (a < 1024) check(mem[a] == model[a], "R3 R5 array byte", {24'h0, mem[a]}, {24'h0, model[a]});
            end
            shadow = rl;
        end

        // R2: reserved bytes ignore writes
        host_write(1'b0, 4'b1011, 32'hFFFF_FFFF);
        host_release();
        win_dw = 1'b0; #1;
        check(win_rdata == 32'h000C_0000, "R2 reserved bytes", win_rdata, 32'h000C_0000);
        // R4: empty byte enable gives no array write
        host_write(1'b1, 4'b0000, 32'hFFFF_FFFF);
        check(arr_we == 1'b0, "R4 no enable no write", {31'h0, arr_we}, 32'h0);
        host_release();
        win_dw = 1'b1; #1;
        check(win_rdata == shadow, "R4 data unchanged", win_rdata, shadow);
        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check(win_rdata == 32'h0, "R1 data after reset", win_rdata, 32'h0);
        win_dw = 1'b0; #1;
        check(win_rdata == 32'h0, "R1 index after reset", win_rdata, 32'h0);
        finish_run();
    end
endmodule